// File: doc/BRIEF.md
# ATA Task-File Command Front End

This block is the register-level front end of an ATA disk device. A host reaches it through a byte-addressed port of eight registers. Five of them hold the command parameters: sector count, the three LBA bytes and the device/head byte. Offset 1 is the feature register when written and the error register when read. Offset 7 takes the command when written and returns status when read. Offset 0 is the 16-bit data port.

Three commands are carried out here.

- **IDENTIFY** returns a table of 256 words through the data port. The table carries a serial-number string, a firmware-version string and a write-cache-enabled flag.
- **FLUSH CACHE** holds the device busy until an external cache controller reports completion on `flush_done`.
- **Data set management (trim)** accepts range entries through the data port and checks each one against the device capacity.

Every command ends with one interrupt, and a status read drops that interrupt. The sector data paths and bus-master DMA are handled elsewhere.

Top module: `ata_cmd_frontend`

## Requirements
- R1: After reset, status (offset 7) reads 0x40 (only the ready bit 6 set), the error register (offset 1) reads 0x00 and `irq` is low.
- R2: Bytes written to offsets 2, 3, 4, 5 and 6 read back unchanged in bits 7:0. A write to offset 1 goes to the feature register and does not alter the error value read at offset 1.
- R3: Command 0xEC makes status read 0x48 (ready bit 6 and data-request bit 3) before every one of 256 data-port reads. Each read advances one word. After the last read, status is 0x40.
- R4: In the IDENTIFY words, words 10–19 carry the 20-character serial string and words 23–26 carry the 8-character version string. The earlier character of each pair sits in bits 15:8. Word 85 equals 0x0020 (bit 5, write cache enabled). Every other word is 0x0000.
- R5: Command 0xE7 makes status read 0xC0 (busy bit 7 and ready bit 6). It raises `flush_start` for exactly one cycle. Status returns to 0x40 in the cycle after `flush_done` is high.
- R6: Command 0x06 with feature bit 0 set and a sector count n of 1 or more makes status read 0x48. The command then takes n × BLOCK_WORDS data-port writes. Each range entry is four consecutive writes, least significant first: the starting LBA in entry bits 47:0 and the sector count in entry bits 63:48.
- R7: When the trim data ends, status is 0x41 with error 0x04 if any entry had a non-zero count with LBA + count greater than CAPACITY. Otherwise status is 0x40 with error 0x00. An entry with a zero count never causes an error.
- R8: An unknown command code, a 0x06 without feature bit 0, or a 0x06 with a sector count of 0 completes at once with status 0x41 and error 0x04 (abort, bit 2).
- R9: `irq` rises once in the cycle after a command completes and stays high until status is read at offset 7. Reading any other offset leaves it high.
- R10: A command written while busy (bit 7) or data request (bit 3) is set is ignored.
- R11: A command written while device register bit 4 is set (device 1 selected) is ignored.
- R12: An accepted command clears the error bit in status and clears the error register.
- R13: The busy and data-request bits are never set together, and the fault bit 5 is always clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset 0..7 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; takes effect at the clock edge |
| reg_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Device interrupt request |
| flush_start | output | 1 | One-cycle request to the cache controller to flush |
| flush_done | input | 1 | Cache controller reports that the flush has finished |

## Verification
The bench reads back the whole IDENTIFY table word by word. A design that is off by one in the word pointer, swaps the bytes within a character pair, or drops the data-request bit early shows a mismatch at a specific word.

Trim ranges are swept across the capacity boundary, with LBA and count chosen so that LBA + count lands below, on and above CAPACITY. A zero-count entry at an absurd LBA is included, and so is a bad entry placed in the second of two blocks. A design using a greater-or-equal compare, a truncated 48-bit sum, or a checker that forgets its error across blocks shows the wrong error state.

Commands are also sent while a flush is in flight and while device 1 is selected, and reads at other offsets are made while `irq` is pending. This catches a front end that accepts a command out of turn or clears its interrupt on the wrong read.

// File: rtl/ata_fe_pkg.sv
package ata_fe_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_IDENT = 2'd1,
      SEQ_FLUSH = 2'd2,
      SEQ_TRIM  = 2'd3
   } seq_state_e;

   localparam logic [2:0] OFS_DATA    = 3'd0;
   localparam logic [2:0] OFS_ERRFEAT = 3'd1;
   localparam logic [2:0] OFS_DEV     = 3'd6;
   localparam logic [2:0] OFS_STATCMD = 3'd7;

   localparam int ST_BUSY  = 7;
   localparam int ST_READY = 6;
   localparam int ST_FAULT = 5;
   localparam int ST_DREQ  = 3;
   localparam int ST_ERR   = 0;

   localparam int DEV_SEL_BIT = 4;

   localparam logic [7:0] ERR_ABORT = 8'h04;

   localparam logic [7:0] OP_IDENT = 8'hEC;
   localparam logic [7:0] OP_FLUSH = 8'hE7;
   localparam logic [7:0] OP_DSM   = 8'h06;

endpackage

// File: rtl/ata_fe_regs.sv
module ata_fe_regs #(
   parameter int FIRST_OFS = 1,
   parameter int LAST_OFS  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] feature,
   output logic [7:0] count,
   output logic [7:0] device,
   output logic [7:0] rd_byte
);
   localparam int N_REGS = LAST_OFS - FIRST_OFS + 1;

   if (FIRST_OFS < 1 || LAST_OFS > 6 || N_REGS < 1) begin : g_bad_range
      $error("ata_fe_regs: register range must lie within offsets 1..6");
   end

   logic [7:0] tf_bytes [FIRST_OFS:LAST_OFS];

   for (genvar i = FIRST_OFS; i <= LAST_OFS; i++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 8'h00;
         else if (wr && addr == 3'(i))
            q <= wdata;
      end
      assign tf_bytes[i] = q;
   end

   assign feature = tf_bytes[1];
   assign count   = tf_bytes[2];
   assign device  = tf_bytes[6];

   always_comb begin
      rd_byte = 8'h00;
      for (int j = FIRST_OFS; j <= LAST_OFS; j++)
         if (addr == 3'(j)) rd_byte = tf_bytes[j];
   end
endmodule

// File: rtl/ata_fe_ident.sv
module ata_fe_ident #(
   parameter int                        WORDS         = 256,
   parameter int                        SERIAL_CHARS  = 20,
   parameter int                        VERSION_CHARS = 8,
   parameter logic [8*SERIAL_CHARS-1:0]  SERIAL_STR    = "SN0042A7            ",
   parameter logic [8*VERSION_CHARS-1:0] VERSION_STR   = "rev1.03 ",
   parameter int                        SERIAL_BASE   = 10,
   parameter int                        VERSION_BASE  = 23,
   parameter int                        FEATURE_WORD  = 85,
   parameter int                        WCACHE_BIT    = 5
) (
   input  logic [$clog2(WORDS)-1:0] idx,
   output logic [15:0]              word
);
   localparam int SERIAL_WORDS  = SERIAL_CHARS / 2;
   localparam int VERSION_WORDS = VERSION_CHARS / 2;

   if ((SERIAL_CHARS % 2) != 0 || (VERSION_CHARS % 2) != 0) begin : g_odd
      $error("ata_fe_ident: string lengths must be even");
   end
   if (SERIAL_BASE + SERIAL_WORDS > WORDS || VERSION_BASE + VERSION_WORDS > WORDS ||
       FEATURE_WORD >= WORDS || WCACHE_BIT > 15) begin : g_fit
      $error("ata_fe_ident: fields do not fit the table");
   end

   always_comb begin : p_word
      int n;
      n    = int'(idx);
      word = 16'h0000;
      if (n >= SERIAL_BASE && n < SERIAL_BASE + SERIAL_WORDS)
         word = SERIAL_STR[8*(SERIAL_CHARS - 2*(n - SERIAL_BASE)) - 1 -: 16];
      else if (n >= VERSION_BASE && n < VERSION_BASE + VERSION_WORDS)
         word = VERSION_STR[8*(VERSION_CHARS - 2*(n - VERSION_BASE)) - 1 -: 16];
      else if (n == FEATURE_WORD)
         word[WCACHE_BIT] = 1'b1;
   end
endmodule

// File: rtl/ata_fe_range.sv
module ata_fe_range #(
   parameter int              DATA_W   = 16,
   parameter int              LBA_W    = 48,
   parameter int              CNT_W    = 16,
   parameter longint unsigned CAPACITY = 131072
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word,
   output logic              entry_done,
   output logic              entry_bad
);
   localparam int ENTRY_W = LBA_W + CNT_W;
   localparam int PARTS   = ENTRY_W / DATA_W;
   localparam int PH_W    = (PARTS > 1) ? $clog2(PARTS) : 1;
   localparam logic [LBA_W:0] CAP_V = (LBA_W + 1)'(CAPACITY);

   if (ENTRY_W % DATA_W != 0 || PARTS < 2) begin : g_bad_split
      $error("ata_fe_range: entry must split into two or more data words");
   end

   logic [PH_W-1:0]   phase;
   logic [DATA_W-1:0] part_q [PARTS-1];
   logic [ENTRY_W-1:0] entry;
   logic [LBA_W-1:0]   lba;
   logic [CNT_W-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clear)
         phase <= '0;
      else if (word_valid)
         phase <= (phase == PH_W'(PARTS - 1)) ? '0 : phase + 1'b1;
   end

   for (genvar p = 0; p < PARTS - 1; p++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            part_q[p] <= '0;
         else if (word_valid && phase == PH_W'(p))
            part_q[p] <= word;
      end
      assign entry[p*DATA_W +: DATA_W] = part_q[p];
   end
   assign entry[ENTRY_W-1 -: DATA_W] = word;

   assign lba = entry[LBA_W-1:0];
   assign cnt = entry[ENTRY_W-1 -: CNT_W];

   assign entry_done = word_valid && phase == PH_W'(PARTS - 1);
   assign entry_bad  = (cnt != '0) &&
                       (({1'b0, lba} + (LBA_W + 1)'(cnt)) > CAP_V);
endmodule

// File: rtl/ata_fe_seq.sv
module ata_fe_seq
   import ata_fe_pkg::*;
#(
   parameter int IDENT_WORDS = 256,
   parameter int BLOCK_WORDS = 256
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cmd_wr,
   input  logic [7:0]                     cmd,
   input  logic                           trim_enable,
   input  logic [7:0]                     count,
   input  logic                           dev1_sel,
   input  logic                           data_rd,
   input  logic                           data_wr,
   input  logic                           status_rd,
   input  logic                           flush_done,
   input  logic                           range_done,
   input  logic                           range_bad,
   output seq_state_e                     state,
   output logic                           bsy,
   output logic                           drq,
   output logic                           err,
   output logic [7:0]                     err_reg,
   output logic [$clog2(IDENT_WORDS)-1:0] ident_idx,
   output logic                           flush_start,
   output logic                           trim_clear,
   output logic                           done_pulse,
   output logic                           irq
);
   localparam int IDX_W = $clog2(IDENT_WORDS);
   localparam int REM_W = 8 + $clog2(BLOCK_WORDS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IDENT_WORDS - 1);

   logic [REM_W-1:0] remain;
   logic             trim_bad;
   logic             trim_bad_now;
   logic             accept;
   logic             known;
   logic             done_ident;
   logic             done_flush;
   logic             done_trim;
   logic             abort_now;

   assign known = (cmd == OP_IDENT) || (cmd == OP_FLUSH) ||
                  (cmd == OP_DSM && trim_enable && count != 8'h00);

   assign accept       = cmd_wr && state == SEQ_IDLE && !dev1_sel;
   assign abort_now    = accept && !known;
   assign done_ident   = state == SEQ_IDENT && data_rd && ident_idx == LAST_IDX;
   assign done_flush   = state == SEQ_FLUSH && flush_done;
   assign done_trim    = state == SEQ_TRIM && data_wr && remain == REM_W'(1);
   assign done_pulse   = done_ident || done_flush || done_trim || abort_now;
   assign trim_bad_now = trim_bad || (range_done && range_bad);
   assign trim_clear   = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SEQ_IDLE;
         bsy         <= 1'b0;
         drq         <= 1'b0;
         err         <= 1'b0;
         err_reg     <= 8'h00;
         ident_idx   <= '0;
         remain      <= '0;
         trim_bad    <= 1'b0;
         flush_start <= 1'b0;
         irq         <= 1'b0;
      end else begin
         flush_start <= 1'b0;

         if (done_pulse)
            irq <= 1'b1;
         else if (status_rd)
            irq <= 1'b0;

         unique case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  err     <= 1'b0;
                  err_reg <= 8'h00;
                  if (!known) begin
                     err     <= 1'b1;
                     err_reg <= ERR_ABORT;
                  end else if (cmd == OP_IDENT) begin
                     state     <= SEQ_IDENT;
                     drq       <= 1'b1;
                     ident_idx <= '0;
                  end else if (cmd == OP_FLUSH) begin
                     state       <= SEQ_FLUSH;
                     bsy         <= 1'b1;
                     flush_start <= 1'b1;
                  end else begin
                     state    <= SEQ_TRIM;
                     drq      <= 1'b1;
                     trim_bad <= 1'b0;
                     remain   <= REM_W'(count) * REM_W'(BLOCK_WORDS);
                  end
               end
            end
            SEQ_IDENT: begin
               if (data_rd) begin
                  if (done_ident) begin
                     state <= SEQ_IDLE;
                     drq   <= 1'b0;
                  end
                  ident_idx <= ident_idx + 1'b1;
               end
            end
            SEQ_FLUSH: begin
               if (done_flush) begin
                  state <= SEQ_IDLE;
                  bsy   <= 1'b0;
               end
            end
            SEQ_TRIM: begin
               if (data_wr) begin
                  trim_bad <= trim_bad_now;
                  remain   <= remain - 1'b1;
                  if (done_trim) begin
                     state   <= SEQ_IDLE;
                     drq     <= 1'b0;
                     err     <= trim_bad_now;
                     err_reg <= trim_bad_now ? ERR_ABORT : 8'h00;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ata_cmd_frontend.sv
module ata_cmd_frontend
   import ata_fe_pkg::*;
#(
   parameter int                        DATA_W        = 16,
   parameter int                        IDENT_WORDS   = 256,
   parameter int                        BLOCK_WORDS   = 256,
   parameter int                        LBA_W         = 48,
   parameter int                        CNT_W         = 16,
   parameter longint unsigned           CAPACITY      = 131072,
   parameter int                        SERIAL_CHARS  = 20,
   parameter int                        VERSION_CHARS = 8,
   parameter logic [8*SERIAL_CHARS-1:0]  SERIAL_STR    = "SN0042A7            ",
   parameter logic [8*VERSION_CHARS-1:0] VERSION_STR   = "rev1.03 "
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        irq,
   output logic        flush_start,
   input  logic        flush_done
);
   localparam int ENTRY_WORDS = (LBA_W + CNT_W) / DATA_W;

   if (DATA_W != 16) begin : g_bad_width
      $error("ata_cmd_frontend: data port must be 16 bits");
   end
   if (IDENT_WORDS < 2 || (IDENT_WORDS & (IDENT_WORDS - 1)) != 0) begin : g_bad_ident
      $error("ata_cmd_frontend: IDENT_WORDS must be a power of two");
   end
   if (BLOCK_WORDS % ENTRY_WORDS != 0) begin : g_bad_block
      $error("ata_cmd_frontend: a block must hold whole range entries");
   end

   logic [7:0]  feature;
   logic [7:0]  count;
   logic [7:0]  device;
   logic [7:0]  tf_byte;
   logic [15:0] ident_word;
   logic [$clog2(IDENT_WORDS)-1:0] ident_idx;
   seq_state_e  state;
   logic        bsy, drq, err;
   logic [7:0]  err_reg;
   logic [7:0]  status;
   logic        trim_clear, done_pulse;
   logic        range_done, range_bad;
   logic        trim_word;

   ata_fe_regs #(.FIRST_OFS(1), .LAST_OFS(6)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata[7:0]),
      .feature (feature),
      .count   (count),
      .device  (device),
      .rd_byte (tf_byte)
   );

   ata_fe_ident #(
      .WORDS         (IDENT_WORDS),
      .SERIAL_CHARS  (SERIAL_CHARS),
      .VERSION_CHARS (VERSION_CHARS),
      .SERIAL_STR    (SERIAL_STR),
      .VERSION_STR   (VERSION_STR)
   ) u_ident (
      .idx  (ident_idx),
      .word (ident_word)
   );

   assign trim_word = reg_wr && reg_addr == OFS_DATA && state == SEQ_TRIM;

   ata_fe_range #(
      .DATA_W   (DATA_W),
      .LBA_W    (LBA_W),
      .CNT_W    (CNT_W),
      .CAPACITY (CAPACITY)
   ) u_range (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (trim_clear),
      .word_valid (trim_word),
      .word       (reg_wdata),
      .entry_done (range_done),
      .entry_bad  (range_bad)
   );

   ata_fe_seq #(
      .IDENT_WORDS (IDENT_WORDS),
      .BLOCK_WORDS (BLOCK_WORDS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (reg_wr && reg_addr == OFS_STATCMD),
      .cmd         (reg_wdata[7:0]),
      .trim_enable (feature[0]),
      .count       (count),
      .dev1_sel    (device[DEV_SEL_BIT]),
      .data_rd     (reg_rd && reg_addr == OFS_DATA),
      .data_wr     (reg_wr && reg_addr == OFS_DATA),
      .status_rd   (reg_rd && reg_addr == OFS_STATCMD),
      .flush_done  (flush_done),
      .range_done  (range_done),
      .range_bad   (range_bad),
      .state       (state),
      .bsy         (bsy),
      .drq         (drq),
      .err         (err),
      .err_reg     (err_reg),
      .ident_idx   (ident_idx),
      .flush_start (flush_start),
      .trim_clear  (trim_clear),
      .done_pulse  (done_pulse),
      .irq         (irq)
   );

   always_comb begin
      status           = 8'h00;
      status[ST_BUSY]  = bsy;
      status[ST_READY] = 1'b1;
      status[ST_FAULT] = 1'b0;
      status[ST_DREQ]  = drq;
      status[ST_ERR]   = err;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_DATA:    reg_rdata = (state == SEQ_IDENT) ? ident_word : 16'h0000;
         OFS_ERRFEAT: reg_rdata = {8'h00, err_reg};
         OFS_STATCMD: reg_rdata = {8'h00, status};
         default:     reg_rdata = {8'h00, tf_byte};
      endcase
   end
endmodule

// File: rtl/ata_cmd_frontend_checker.sv
module ata_cmd_frontend_checker
   import ata_fe_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  reg_addr,
   input logic        reg_rd,
   input logic        irq,
   input logic        flush_start,
   input logic        bsy,
   input logic        drq,
   input logic        err,
   input logic [7:0]  err_reg,
   input logic        done_pulse,
   input seq_state_e  state
);
   assert_bsy_drq_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(bsy && drq));

   assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == OFS_STATCMD && !done_pulse) |=> !irq);

   assert_irq_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !done_pulse) |=> !irq);

   assert_flush_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_start |-> (bsy && state == SEQ_FLUSH));

   assert_err_abrt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (err_reg == ERR_ABORT));

   assert_ident_drq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDENT) |-> (drq && !bsy));
endmodule

bind ata_cmd_frontend ata_cmd_frontend_checker u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_addr    (reg_addr),
   .reg_rd      (reg_rd),
   .irq         (irq),
   .flush_start (flush_start),
   .bsy         (bsy),
   .drq         (drq),
   .err         (err),
   .err_reg     (err_reg),
   .done_pulse  (done_pulse),
   .state       (state)
);

// File: tb/ata_cmd_frontend_bench.sv
module ata_cmd_frontend_bench;
   localparam int              BLK   = 16;
   localparam longint unsigned CAP   = 1000;
   localparam logic [159:0]    SER   = "QX7731-ZB09         ";
   localparam logic [63:0]     VER   = "fw2.6   ";

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic        flush_start;
   logic        flush_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ata_cmd_frontend #(
      .BLOCK_WORDS (BLK),
      .CAPACITY    (CAP),
      .SERIAL_STR  (SER),
      .VERSION_STR (VER)
   ) u_ata_cmd_frontend (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_addr    (reg_addr),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq),
      .flush_start (flush_start),
      .flush_done  (flush_done)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send_entry(logic [47:0] lba, logic [15:0] cnt);
      logic [63:0] e;
      e = {cnt, lba};
      for (int p = 0; p < 4; p++) wr_reg(3'd0, e[16*p +: 16]);
   endtask

   function automatic logic [15:0] exp_ident(int i);
      if (i >= 10 && i < 20)
         return {SER[8*(19 - 2*(i-10)) +: 8], SER[8*(18 - 2*(i-10)) +: 8]};
      if (i >= 23 && i < 27)
         return {VER[8*(7 - 2*(i-23)) +: 8], VER[8*(6 - 2*(i-23)) +: 8]};
      if (i == 85) return 16'h0020;
      return 16'h0000;
   endfunction

   // one-block trim with a single entry under test, rest zero-count entries
   task automatic trim_one(logic [47:0] lba, logic [15:0] cnt, string req);
      logic [15:0] v;
      logic        bad;
      bad = (cnt != 0) && ({1'b0, lba} + 49'(cnt) > 49'(CAP));
      wr_reg(3'd1, 16'h0001);
      wr_reg(3'd2, 16'h0001);
      wr_reg(3'd7, 16'h0006);
      rd_reg(3'd7, v); chk({req, " R6 drq"}, v, 16'h0048);
      send_entry(lba, cnt);
      for (int k = 1; k < BLK/4; k++) send_entry(48'h0, 16'h0);
      chk({req, " R9 irq"}, {15'h0, irq}, 16'h0001);
      rd_reg(3'd1, v); chk({req, " R7 error"}, v, bad ? 16'h0004 : 16'h0000);
      rd_reg(3'd7, v); chk({req, " R7 status"}, v, bad ? 16'h0041 : 16'h0040);
   endtask

   initial begin : watchdog
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(3'd1, v); chk("R1 error reg", v, 16'h0000);
      chk("R1 irq", {15'h0, irq}, 16'h0000);
      rd_reg(3'd7, v); chk("R1 status", v, 16'h0040);

      // R2 register storage
      for (int a = 2; a <= 6; a++) begin
         wr_reg(3'(a), 16'h00A0 + 16'(a * 7));
         rd_reg(3'(a), v); chk("R2 readback", v, 16'h00A0 + 16'(a * 7));
      end
      wr_reg(3'd1, 16'h00FF);
      rd_reg(3'd1, v); chk("R2 feature not in error", v, 16'h0000);

      // R11 device 1 selected: command ignored
      wr_reg(3'd6, 16'h0010);
      wr_reg(3'd7, 16'h00EC);
      chk("R11 irq", {15'h0, irq}, 16'h0000);
      rd_reg(3'd7, v); chk("R11 status", v, 16'h0040);
      rd_reg(3'd6, v); chk("R11 device", v, 16'h0010);

      // R8 unknown command
      wr_reg(3'd6, 16'h0040);
      wr_reg(3'd7, 16'h0055);
      chk("R8 irq", {15'h0, irq}, 16'h0001);
      rd_reg(3'd2, v);
      chk("R9 irq kept on other read", {15'h0, irq}, 16'h0001);
      rd_reg(3'd1, v); chk("R8 unknown error", v, 16'h0004);
      rd_reg(3'd7, v); chk("R8 unknown status", v, 16'h0041);
      chk("R9 irq cleared", {15'h0, irq}, 16'h0000);

      // R3 R4 R12 identify
      wr_reg(3'd7, 16'h00EC);
      rd_reg(3'd1, v); chk("R12 error cleared", v, 16'h0000);
      for (int i = 0; i < 256; i++) begin
         rd_reg(3'd7, v); chk("R3 status per word", v, 16'h0048);
         rd_reg(3'd0, v); chk("R4 identify word", v, exp_ident(i));
      end
      chk("R9 identify irq", {15'h0, irq}, 16'h0001);
      rd_reg(3'd7, v); chk("R3 final status", v, 16'h0040);
      rd_reg(3'd6, v); chk("R3 device bit4 clear", v & 16'h0010, 16'h0000);

      // R5 R10 flush
      wr_reg(3'd7, 16'h00E7);
      chk("R5 flush_start", {15'h0, flush_start}, 16'h0001);
      @(negedge clk);
      chk("R5 flush_start one cycle", {15'h0, flush_start}, 16'h0000);
      rd_reg(3'd7, v); chk("R5 busy status", v, 16'h00C0);
      wr_reg(3'd7, 16'h00EC);
      repeat (5) @(negedge clk);
      rd_reg(3'd7, v); chk("R10 still busy", v, 16'h00C0);
      chk("R5 no irq in flight", {15'h0, irq}, 16'h0000);
      @(negedge clk); flush_done = 1'b1;
      @(negedge clk); flush_done = 1'b0;
      chk("R9 flush irq", {15'h0, irq}, 16'h0001);
      rd_reg(3'd7, v); chk("R10 R5 done status", v, 16'h0040);

      // R8 trim abort variants
      wr_reg(3'd1, 16'h0000); wr_reg(3'd2, 16'h0001);
      wr_reg(3'd7, 16'h0006);
      rd_reg(3'd7, v); chk("R8 trim no feature", v, 16'h0041);
      wr_reg(3'd1, 16'h0001); wr_reg(3'd2, 16'h0000);
      wr_reg(3'd7, 16'h0006);
      rd_reg(3'd1, v); chk("R8 trim zero count error", v, 16'h0004);
      rd_reg(3'd7, v); chk("R8 trim zero count", v, 16'h0041);

      // R6 R7 boundary sweep
      for (int d = 0; d <= 3; d++)
         for (int c = 0; c <= 4; c++)
            trim_one(48'(CAP - longint'(d)), 16'(c), "R7 sweep");
      trim_one(48'hFFFF_FFFF_FFFF, 16'h0000, "R7 zero count huge lba");
      trim_one(48'hFFFF_FFFF_FFFF, 16'h0001, "R7 overflow lba");
      trim_one(48'h0, 16'(CAP), "R7 whole device");
      trim_one(48'h0, 16'(CAP + 1), "R7 one past");

      // R6 R7 two blocks, bad entry in second block
      wr_reg(3'd1, 16'h0001); wr_reg(3'd2, 16'h0002);
      wr_reg(3'd7, 16'h0006);
      for (int k = 0; k < BLK/4; k++) send_entry(48'd10, 16'd5);
      rd_reg(3'd7, v); chk("R6 mid-command drq", v, 16'h0048);
      send_entry(48'd999, 16'd2);
      for (int k = 1; k < BLK/4; k++) send_entry(48'd0, 16'd1);
      rd_reg(3'd1, v); chk("R7 second block error", v, 16'h0004);
      rd_reg(3'd7, v); chk("R7 second block status", v, 16'h0041);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule